// File: doc/BRIEF.md
# Reference clock ratio range detector

This block works out roughly how much faster a local system clock runs than a slower, unrelated reference clock. It counts system clock cycles across each period of the reference, then sorts the finished count into one of three coarse bands. The result is a 2-bit status code with a valid flag. Other logic reads the code as status, and can use it to pick a divider setting on its own.

The reference clock arrives without any timing relation to the system clock. It is brought into the system domain through a two-flop synchronizer, and a rising edge is then detected there. The distance between two consecutive detected edges, in system cycles, is the measured ratio. The period counter stops at its all-ones value rather than wrapping. A reference that is very slow therefore still lands in the top band.

Top module: `ref_ratio_detector`

## Requirements
- R1: While reset is asserted (synchronous, active low), and on the first cycle after it, `range_valid` is 0 and `range_code` is 2'b00.
- R2: The first synchronized rising edge after reset completes no period. `range_valid` stays 0 and `range_code` stays 2'b00 until the second rising edge has been processed.
- R3: The measured value is the number of system clock cycles between two consecutive synchronized rising edges of the reference. A measured value below 96 gives code 2'b10.
- R4: A measured value from 96 to 224, both ends included, gives code 2'b01.
- R5: A measured value above 224 gives code 2'b00.
- R6: Code 2'b11 is reserved and never appears on `range_code`.
- R7: The period counter saturates at 2^CNT_W-1 (1023 by default) and does not wrap. Any period of 1023 cycles or longer, including a period that ends exactly at saturation, reports code 2'b00.
- R8: `range_code` and `range_valid` change only in the cycle in which a period completes. Once `range_valid` is 1 it stays 1 until reset.
- R9: The reference passes through two synchronizer flops. A reference rising edge that is set up before system clock edge k shows its result on the outputs just after clock edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Fast system clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_async | input | 1 | Slow reference clock, asynchronous to clk_sys |
| range_code | output | 2 | 00: ratio above 224; 01: 96 to 224; 10: below 96; 11 unused |
| range_valid | output | 1 | High once a full reference period has been measured |

## Verification
Two things can happen in the same cycle: the counter reaching its saturation value, and a reference edge that captures the count and restarts the counter. Periods of exactly 1023 and 1024 cycles are driven so that the capture and the saturating increment meet, or just miss, on one edge. Both must report code 00, and the next period must measure from a fresh start. A 1100-cycle period then shows that a wrapped count, which would read as the low band, never appears. A scoreboard judges each result at the exact latency cycle, and the held outputs are compared on every other cycle.

// File: rtl/rrd_pkg.sv
// Package: shared range code encoding for the reference ratio detector.
// Assumes: code values are consumed by neighbouring logic, so they are fixed.
package rrd_pkg;
    typedef enum logic [1:0] {
        RANGE_HIGH = 2'b00,  // ratio above the upper limit
        RANGE_MID  = 2'b01,  // ratio between the limits, inclusive
        RANGE_LOW  = 2'b10,  // ratio below the lower limit
        RANGE_RSVD = 2'b11   // never produced
    } range_code_e;
endpackage

// File: rtl/rrd_edge_sync.sv
// Module: rrd_edge_sync
// Brings an asynchronous level into the clk domain through STAGES flops and
// emits a one-cycle pulse on each synchronized rising edge.
// Assumes: STAGES >= 2; the input stays high/low for at least two clk cycles.
module rrd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Synchronizer chain: stage 0 samples the raw input.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    // Rising edge pulse in the clk domain.
    always_comb rise_o = chain_q[STAGES-1] & ~last_q;

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/rrd_period_counter.sv
// Module: rrd_period_counter
// Counts clk cycles between synchronized rising edges. The count saturates at
// its all-ones value. On each edge after the first it presents the finished
// count with a one-cycle complete pulse, then restarts at 1.
// Assumes: rise_i is a single-cycle pulse.
module rrd_period_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    output logic [CNT_W-1:0] period_o,
    output logic             complete_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    // Cycle counter: restart on an edge, otherwise saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (rise_i)         cnt_q <= CNT_ONE;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
    end

    // Armed once the first edge has opened a period.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed_q <= 1'b0;
        else if (rise_i) armed_q <= 1'b1;
    end

    // A period completes on any edge that follows an earlier edge.
    always_comb begin
        complete_o = rise_i & armed_q;
        period_o   = cnt_q;
    end

    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_i |=> (cnt_q >= $past(cnt_q)));
    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> (cnt_q == CNT_ONE));
endmodule

// File: rtl/rrd_range_classify.sv
// Module: rrd_range_classify
// Maps a finished period count onto the three-band range code.
// Assumes: LO_LIMIT <= HI_LIMIT < 2**CNT_W.
module rrd_range_classify
    import rrd_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int LO_LIMIT = 96,
    parameter int HI_LIMIT = 224
) (
    input  logic [CNT_W-1:0] period_i,
    output range_code_e      code_o
);
    localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO_LIMIT);
    localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI_LIMIT);

    // Band selection, inclusive at both limits for the middle band.
    always_comb begin
        if (period_i > HI_C)       code_o = RANGE_HIGH;
        else if (period_i >= LO_C) code_o = RANGE_MID;
        else                       code_o = RANGE_LOW;
    end
endmodule

// File: rtl/ref_ratio_detector.sv
// Module: ref_ratio_detector (top)
// Measures system clock cycles per reference period and publishes a
// registered 2-bit range code plus valid flag on each completed period.
// Assumes: the reference runs slower than clk_sys / 4 with both phases >= 2 cycles.
module ref_ratio_detector
    import rrd_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2,
    parameter int LO_LIMIT    = 96,
    parameter int HI_LIMIT    = 224
) (
    input  logic       clk_sys,
    input  logic       rst_n,
    input  logic       ref_clk_async,
    output logic [1:0] range_code,
    output logic       range_valid
);
    logic             ref_rise;
    logic [CNT_W-1:0] period;
    logic             complete;
    range_code_e      band;
    range_code_e      code_q;
    logic             valid_q;

    rrd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_sys),
        .rst_n    (rst_n),
        .async_in (ref_clk_async),
        .rise_o   (ref_rise)
    );

    rrd_period_counter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk_sys),
        .rst_n      (rst_n),
        .rise_i     (ref_rise),
        .period_o   (period),
        .complete_o (complete)
    );

    rrd_range_classify #(
        .CNT_W    (CNT_W),
        .LO_LIMIT (LO_LIMIT),
        .HI_LIMIT (HI_LIMIT)
    ) u_class (
        .period_i (period),
        .code_o   (band)
    );

    // Status register: load the band only when a period completes.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) begin
            code_q  <= RANGE_HIGH;
            valid_q <= 1'b0;
        end else if (complete) begin
            code_q  <= band;
            valid_q <= 1'b1;
        end
    end

    // Drive the plain output ports.
    always_comb begin
        range_code  = code_q;
        range_valid = valid_q;
    end

    a_r6_no_reserved: assert property (@(posedge clk_sys) disable iff (!rst_n)
        range_code != 2'b11);
    a_r8_hold: assert property (@(posedge clk_sys) disable iff (!rst_n)
        !complete |=> ($stable(range_code) && $stable(range_valid)));
    a_r8_valid_sticky: assert property (@(posedge clk_sys) disable iff (!rst_n)
        range_valid |=> range_valid);
    a_r2_first_valid: assert property (@(posedge clk_sys) disable iff (!rst_n)
        $rose(range_valid) |-> $past(complete));
endmodule

// File: tb/ref_ratio_detector_tb_top.sv
module ref_ratio_detector_tb_top;
    logic       clk_sys = 1'b0;
    logic       rst_n   = 1'b0;
    logic       ref_clk_async = 1'b0;
    logic [1:0] range_code;
    logic       range_valid;

    ref_ratio_detector dut_i (
        .clk_sys       (clk_sys),
        .rst_n         (rst_n),
        .ref_clk_async (ref_clk_async),
        .range_code    (range_code),
        .range_valid   (range_valid)
    );

    always #2 clk_sys = ~clk_sys;  // 250 MHz

    typedef struct {
        int         stamp;
        logic       valid;
        logic [1:0] code;
        string      req;
    } exp_t;

    exp_t       sb_q[$];
    int         cyc = 0;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         mon_en = 0;
    bit         armed = 0;
    int         prev_gap = 0;
    logic       held_valid = 1'b0;
    logic [1:0] held_code = 2'b00;

    always @(posedge clk_sys) cyc <= cyc + 1;

    // Expected band from the requirements (R3/R4/R5/R7).
    function automatic logic [1:0] band_of(input int p);
        int s = (p > 1023) ? 1023 : p;
        if (s > 224) return 2'b00;
        if (s >= 96) return 2'b01;
        return 2'b10;
    endfunction

    function automatic string req_of(input int p);
        if (p >= 1023) return "R7";
        if (p > 224)   return "R5";
        if (p >= 96)   return "R4";
        return "R3";
    endfunction

    // Driver: raise the reference now, push the expectation, and hold the
    // next rise exactly gap cycles away. Called at a negedge.
    task automatic ref_period(input int gap);
        exp_t e;
        int hi = gap / 2;
        ref_clk_async = 1'b1;
        e.stamp = cyc + 3;  // R9: two sync flops plus the status register
        if (armed) begin
            e.valid = 1'b1;
            e.code  = band_of(prev_gap);
            e.req   = req_of(prev_gap);
        end else begin
            e.valid = 1'b0;
            e.code  = 2'b00;
            e.req   = "R2";
        end
        sb_q.push_back(e);
        armed    = 1;
        prev_gap = gap;
        repeat (hi) @(negedge clk_sys);
        ref_clk_async = 1'b0;
        repeat (gap - hi) @(negedge clk_sys);
    endtask

    // Monitor: compare at the predicted cycle, check held values elsewhere (R8, R6).
    always @(negedge clk_sys) begin
        if (mon_en) begin
            if (sb_q.size() > 0 && cyc == sb_q[0].stamp) begin
                n_checks++;
                if (range_valid !== sb_q[0].valid || range_code !== sb_q[0].code) begin
                    n_fail++;
                    $display("FAIL %s: got valid=%0b code=%b, expected valid=%0b code=%b",
                             sb_q[0].req, range_valid, range_code, sb_q[0].valid, sb_q[0].code);
                end
                held_valid = sb_q[0].valid;
                held_code  = sb_q[0].code;
                void'(sb_q.pop_front());
            end else begin
                if (range_valid !== held_valid || range_code !== held_code) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL R8: got valid=%0b code=%b, expected held valid=%0b code=%b",
                             range_valid, range_code, held_valid, held_code);
                end
                if (range_code === 2'b11) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL R6: got code=%b, expected any non-reserved code", range_code);
                end
            end
        end
    end

    task automatic check_idle(input string req);
        n_checks++;
        if (range_valid !== 1'b0 || range_code !== 2'b00) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b code=%b, expected valid=0 code=00",
                     req, range_valid, range_code);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk_sys);
        check_idle("R1");                     // R1 during reset
        rst_n = 1'b1;
        @(negedge clk_sys);
        check_idle("R1");                     // R1 first cycle after reset
        mon_en = 1;
        repeat (5) @(negedge clk_sys);
        // First rise opens a period only (R2); later rises report the previous gap.
        ref_period(60);
        ref_period(95);    // reported by next rise: R3 boundary below 96
        ref_period(96);    // R4 lower boundary
        ref_period(150);
        ref_period(224);   // R4 upper boundary
        ref_period(225);   // R5 just above
        ref_period(400);
        ref_period(1023);  // R7 capture meets saturation
        ref_period(1024);  // R7 one beyond saturation
        ref_period(1100);  // R7 wrap would read as the low band
        ref_period(40);    // R3 after a saturated period
        ref_period(200);
        ref_period(50);
        repeat (10) @(negedge clk_sys);
        mon_en = 0;
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9: got %0d pending results, expected 0", sb_q.size());
        end
        rst_n = 1'b0;                          // R1 reset from a valid state
        @(negedge clk_sys);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk_sys);
        check_idle("R1");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule